// File: doc/BRIEF.md
# Conditional Branch Execute Unit

This unit resolves the three branch forms of a 32-bit RISC instruction word in one place. Each word arrives with the address it was fetched from, the four condition flags and the value of the register named in the word's low nibble. The unit tests the condition, decodes the form and produces the address to fetch next. For a branch-with-link it also produces a write of the return address into the link register (register 14). For a register branch it produces a new value for the instruction-set state bit, which selects the compact 16-bit encoding.

The unit sits in the execute stage of a pipeline. The register file reads the register index from `rm_sel` in the same cycle and returns its contents on `rm_val`. One cycle after a word is presented with `in_valid`, the results appear with `out_valid`. A word that is not a branch, or whose condition fails, produces the sequential address. In that case nothing is taken, nothing is written and the state bit is left as it was. The unit has no flag output, so no form can alter the flags.

Top module: `brx_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives `out_valid`, `taken` and `link_we` low after that edge.
- R2: The results for a word presented with `in_valid` high at a rising edge appear after that edge with `out_valid` high. After any edge where `in_valid` was low, `out_valid`, `taken` and `link_we` are all low.
- R3: The condition is `instr[31:28]`, tested against the flags `flags[3]`=N, `flags[2]`=Z, `flags[1]`=C and `flags[0]`=V. The codes and their tests are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V); 14 always.
- R4: A word with `instr[27:25]`=101 and a passing condition is a PC-relative branch. It is taken, and `next_pc` = `pc` + 8 + (sign-extended `instr[23:0]` shifted left by 2), computed modulo 2^32.
- R5: When a PC-relative branch with `instr[24]`=1 is taken, `link_we` goes high and `link_data` = `pc` + 4. When `instr[24]`=0, `link_we` stays low.
- R6: A word with `instr[27:20]`=00010010, `instr[19:8]`=FFF and `instr[7:4]`=0001 is a register branch. `rm_sel` equals `instr[3:0]` combinationally. When the condition passes, the branch is taken, `next_pc` = `rm_val` with bit 0 cleared, and `mode_out` = `rm_val[0]`.
- R7: When the condition fails, or the word matches neither form (including a register-branch word with any of bits [19:8] at zero), `next_pc` = `pc` + 4, `taken` and `link_we` are low, and `mode_out` equals `mode_in`.
- R8: Condition code 15 never passes, whatever the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and operands are valid |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| flags | input | 4 | Condition flags N, Z, C, V (bit 3 down to bit 0) |
| rm_val | input | 32 | Contents of the register selected by `rm_sel` |
| mode_in | input | 1 | Current instruction-set state bit |
| rm_sel | output | 4 | Register index for the register-branch form |
| out_valid | output | 1 | Results below are valid |
| taken | output | 1 | The branch was taken |
| next_pc | output | 32 | Address to fetch next |
| link_we | output | 1 | Write `link_data` into register 14 |
| link_data | output | 32 | Return address |
| mode_out | output | 1 | New instruction-set state bit |

## Verification
The registered state here is a single result stage, so any error in decode, condition or target arithmetic shows at the ports on the cycle after the word is presented. It appears as a wrong `next_pc`, a spurious or missing `taken` or `link_we`, or a state bit that moves when it should hold. The scoreboard compares every result against a model built from the requirements. It also watches each idle cycle, so a strobe that leaks into a cycle without a word, or a result that arrives a cycle late, breaks the queue order at once. All sixteen condition codes are crossed with all sixteen flag patterns, so a single wrong entry in the condition table is caught.

// File: rtl/brx_unit.sv
module brx_unit #(
  parameter int STEP     = 4,
  parameter int PREFETCH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic [31:0] pc,
  input  logic [3:0]  flags,
  input  logic [31:0] rm_val,
  input  logic        mode_in,
  output logic [3:0]  rm_sel,
  output logic        out_valid,
  output logic        taken,
  output logic [31:0] next_pc,
  output logic        link_we,
  output logic [31:0] link_data,
  output logic        mode_out
);
  localparam logic [31:0] STEP_W = 32'(STEP);
  localparam logic [31:0] AHEAD_W = 32'(PREFETCH);

  logic n, z, c, v, cond_ok;
  assign {n, z, c, v} = flags;

  always_comb begin
    case (instr[31:28])
      4'd0:    cond_ok = z;
      4'd1:    cond_ok = !z;
      4'd2:    cond_ok = c;
      4'd3:    cond_ok = !c;
      4'd4:    cond_ok = n;
      4'd5:    cond_ok = !n;
      4'd6:    cond_ok = v;
      4'd7:    cond_ok = !v;
      4'd8:    cond_ok = c && !z;
      4'd9:    cond_ok = !c || z;
      4'd10:   cond_ok = n == v;
      4'd11:   cond_ok = n != v;
      4'd12:   cond_ok = !z && (n == v);
      4'd13:   cond_ok = z || (n != v);
      4'd14:   cond_ok = 1'b1;
      default: cond_ok = 1'b0;
    endcase
  end

  wire is_rel = instr[27:25] == 3'b101;
  wire is_reg = (instr[27:20] == 8'h12) && (&instr[19:8]) && (instr[7:4] == 4'h1);
  wire go_rel = cond_ok && is_rel;
  wire go_reg = cond_ok && is_reg;

  wire [31:0] off_ext = {{6{instr[23]}}, instr[23:0], 2'b00};
  wire [31:0] seq_pc  = pc + STEP_W;
  wire [31:0] rel_tgt = pc + AHEAD_W + off_ext;
  wire [31:0] reg_tgt = {rm_val[31:1], 1'b0};

  assign rm_sel = instr[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      link_we   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      taken     <= in_valid && (go_rel || go_reg);
      link_we   <= in_valid && go_rel && instr[24];
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      next_pc   <= go_rel ? rel_tgt : (go_reg ? reg_tgt : seq_pc);
      link_data <= seq_pc;
      mode_out  <= go_reg ? rm_val[0] : mode_in;
    end
  end
endmodule

module brx_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] pc,
  input logic        mode_in,
  input logic        out_valid,
  input logic        taken,
  input logic [31:0] next_pc,
  input logic        link_we,
  input logic [31:0] link_data,
  input logic        mode_out
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> !out_valid && !taken && !link_we);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !out_valid |-> !taken && !link_we);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  // R5
  link_ret_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> taken && link_data == $past(pc) + 32'd4);
  // R7
  fallthru_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !taken |-> next_pc == $past(pc) + 32'd4 && mode_out == $past(mode_in));
endmodule

bind brx_unit brx_unit_chk i_chk (.*);

// File: tb/test_brx_unit.sv
module test_brx_unit;
  logic        clk = 0, rst = 1, in_valid = 0, mode_in = 0;
  logic [31:0] instr = 0, pc = 0, rm_val = 0;
  logic [3:0]  flags = 0;
  logic [3:0]  rm_sel;
  logic        out_valid, taken, link_we, mode_out;
  logic [31:0] next_pc, link_data;

  brx_unit i_brx_unit (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [31:0] npc;
    logic        tk;
    logic        lwe;
    logic [31:0] ldata;
    logic        md;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic bit cond_pass(input logic [3:0] cc, input logic [3:0] f);
    bit nn = f[3], zz = f[2], cc1 = f[1], vv = f[0];
    case (cc)
      0: return zz;          1: return !zz;
      2: return cc1;         3: return !cc1;
      4: return nn;          5: return !nn;
      6: return vv;          7: return !vv;
      8: return cc1 & !zz;   9: return !cc1 | zz;
      10: return nn == vv;   11: return nn != vv;
      12: return !zz & (nn == vv);
      13: return zz | (nn != vv);
      14: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic drive(input logic [31:0] w, input logic [31:0] a, input logic [3:0] f,
                       input logic [31:0] r, input logic m, input string tag);
    exp_t e;
    bit ok = cond_pass(w[31:28], f);
    bit rel = w[27:25] == 3'b101;
    bit rg = w[27:4] == 24'h12FFF1;
    @(negedge clk);
    instr = w; pc = a; flags = f; rm_val = r; mode_in = m; in_valid = 1;
    e.tag = tag; e.ldata = a + 4; e.lwe = 0; e.md = m; e.tk = 0; e.npc = a + 4;
    if (ok && rel) begin
      e.tk = 1;
      e.npc = a + 8 + {{6{w[23]}}, w[23:0], 2'b00};
      e.lwe = w[24];
    end else if (ok && rg) begin
      e.tk = 1;
      e.npc = r & 32'hFFFF_FFFE;
      e.md = r[0];
    end
    sb.push_back(e);
    if (rg) begin
      #1 total++;
      if (rm_sel !== w[3:0]) begin
        bad++;
        $display("FAIL R6 rm_sel actual=%h expected=%h", rm_sel, w[3:0]);
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); in_valid = 0; end
  endtask

  always @(negedge clk) if (!rst) begin
    if (out_valid) begin
      exp_t e;
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected result actual=1 expected=0");
      end else begin
        e = sb.pop_front();
        if (taken !== e.tk || link_we !== e.lwe || next_pc !== e.npc || mode_out !== e.md ||
            (e.lwe && link_data !== e.ldata)) begin
          bad++;
          $display("FAIL %s actual tk=%b lwe=%b npc=%h ld=%h md=%b expected tk=%b lwe=%b npc=%h ld=%h md=%b",
                   e.tag, taken, link_we, next_pc, link_data, mode_out,
                   e.tk, e.lwe, e.npc, e.ldata, e.md);
        end
      end
    end else begin
      total++;
      if (taken !== 1'b0 || link_we !== 1'b0) begin
        bad++;
        $display("FAIL R2 idle strobes actual tk=%b lwe=%b expected 0 0", taken, link_we);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 0 || taken !== 0 || link_we !== 0) begin
      bad++;
      $display("FAIL R1 reset actual ov=%b tk=%b lwe=%b expected 0 0 0", out_valid, taken, link_we);
    end
    rst = 0;
    // R4 forward, backward, most negative offset
    drive(32'hEA000010, 32'h0000_1000, 4'h0, 0, 0, "R4 fwd");
    drive(32'hEAFFFFFE, 32'h0000_1000, 4'h0, 0, 0, "R4 back");
    drive(32'hEA800000, 32'h0400_0000, 4'h0, 0, 1, "R4 minoff");
    idle(2);
    // R5 link and no link
    drive(32'hEB000001, 32'h0000_2000, 4'h0, 0, 0, "R5 link");
    drive(32'hEBFFFFFF, 32'h0000_0010, 4'h0, 0, 1, "R5 link back");
    drive(32'h0A000004, 32'h0000_3000, 4'h4, 0, 0, "R5 nolink");
    // R6 register branch
    drive(32'hE12FFF13, 32'h0000_5000, 4'h0, 32'h0000_4001, 0, "R6 odd");
    drive(32'hE12FFF1E, 32'h0000_5004, 4'h0, 32'h8000_0100, 1, "R6 even");
    drive(32'h112FFF15, 32'h0000_5008, 4'h0, 32'h0000_7777, 0, "R6 cond");
    // R7 unmatched and failing
    drive(32'hE0812003, 32'h0000_6000, 4'h0, 32'h1, 1, "R7 other");
    drive(32'hE12FFE13, 32'h0000_6004, 4'h0, 32'h1, 0, "R7 sbo");
    drive(32'h1B000008, 32'h0000_6008, 4'h4, 32'h1, 1, "R7 failbl");
    drive(32'h012FFF11, 32'h0000_600C, 4'h0, 32'h3, 1, "R7 failbx");
    idle(1);
    // R3 and R8 full table
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++) begin
        drive({cc[3:0], 4'hA, 24'h000003}, 32'h100 + 32'(cc * 64 + f * 4), f[3:0], 0, 0,
              cc == 15 ? "R8 never" : "R3 cond");
        if (f == 7) idle(1);
      end
    drive(32'hFB000002, 32'h0000_9000, 4'hF, 0, 0, "R8 bl never");
    idle(3);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R2 pending actual=%0d expected=0", sb.size());
    end
    // R1 reset mid-run
    drive(32'hEA000000, 32'h0000_A000, 4'h0, 0, 0, "R1 pre");
    @(negedge clk);
    in_valid = 0;
    rst = 1;
    void'(sb.pop_front());
    @(negedge clk);
    total++;
    if (out_valid !== 0 || taken !== 0 || link_we !== 0) begin
      bad++;
      $display("FAIL R1 midreset actual ov=%b tk=%b lwe=%b expected 0 0 0", out_valid, taken, link_we);
    end
    rst = 0;
    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule